// File: doc/BRIEF.md
# Sixteen-Function Microcode ALU

This block is the arithmetic unit of a microcoded datapath. Each cycle it takes two 32-bit operands from the source buses and a 4-bit function code, and presents a 32-bit result on the destination bus with no clock in the path. Its operation set serves firmware that interprets instructions. Along with the usual logic and add operations, it provides fixed left shifts by 2 and by 10, a right shift by 5, a variable logical right shift, extraction of a 13-bit immediate, sign extension of a 13-bit immediate, increment by one and increment by four.

A four-bit flag register holds negative, zero, overflow and carry. Only the four lowest function codes load it, and only on a clock edge while the flag-enable strobe is high. All other codes give the same results as their flagged counterparts, or perform helper operations, and leave the flags untouched. Firmware can therefore run scratch computations between a compare and the branch that tests it. Subtraction is not a function of its own: firmware builds it from NOR, increment and add.

Top module: `ucode_alu`

## Requirements
- R1: Codes 0 (0000), 1 (0001), 2 (0010) and 5, 6, 7 (0101, 0110, 0111) produce the result a AND b, a OR b, and NOT(a OR b) respectively, with codes 5, 6 and 7 repeating codes 0, 1 and 2.
- R2: Codes 3 (0011) and 8 (1000) produce a + b modulo 2^32 in two's complement.
- R3: Code 4 (0100) shifts a right logically by b[4:0] places, inserting zeros. Bits b[31:5] have no effect on the result.
- R4: Codes 9 (1001) and 10 (1010) shift a left by 2 and by 10 places, filling with zeros. Code 15 (1111) shifts a right by 5 places, filling with zeros.
- R5: Code 11 (1011) gives {19'b0, a[12:0]}. Code 12 (1100) gives a[12:0] sign-extended from bit 12.
- R6: Code 13 (1101) gives a + 1 and code 14 (1110) gives a + 4, both modulo 2^32. Neither depends on b.
- R7: When flag_en is high at a rising clock edge and the code is 0 to 3, the flag register {n,z,v,c} loads n = result[31] and z = (result == 0).
- R8: For code 3 the flags also load c = the carry out of bit 31 and v = 1 when a[31] == b[31] and result[31] != a[31]. For codes 0 to 2, v and c load 0.
- R9: The flags keep their value when the code is 4 to 15 or when flag_en is low.
- R10: A synchronous reset, rst high at a clock edge, clears all four flags and takes priority over any update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags change on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fn | input | 4 | Function code |
| flag_en | input | 1 | Allows flag-setting codes to load the flag register |
| a_bus | input | 32 | Operand A |
| b_bus | input | 32 | Operand B |
| c_bus | output | 32 | Combinational result |
| flags | output | 4 | Flag register {n, z, v, c} |

## Verification
The result path has no state, so a faulty operation appears on c_bus in the same cycle the code is applied. The only internal state is the flag register. A wrong update, a missed update, or an update by a code that should leave the flags alone shows up on the flags port one edge later. It then persists until the next legitimate load. The bench therefore compares flags after every edge, including long runs of codes that must leave the flags alone, so a stale or corrupted value cannot hide.

// File: rtl/ucode_alu.sv
module ucode_alu #(
  parameter int W = 32,
  parameter int IMM = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   fn,
  input  logic         flag_en,
  input  logic [W-1:0] a_bus,
  input  logic [W-1:0] b_bus,
  output logic [W-1:0] c_bus,
  output logic [3:0]   flags
);
  localparam int SH = $clog2(W);

  logic [W:0]   sum;
  logic [W-1:0] inc_val;
  logic         is_cc, add_v;

  assign sum     = {1'b0, a_bus} + {1'b0, b_bus};
  assign inc_val = a_bus + ((fn == 4'd14) ? W'(4) : W'(1));
  assign is_cc   = (fn[3:2] == 2'b00);
  assign add_v   = (a_bus[W-1] == b_bus[W-1]) && (sum[W-1] != a_bus[W-1]);

  always_comb begin
    case (fn)
      4'd0, 4'd5:   c_bus = a_bus & b_bus;
      4'd1, 4'd6:   c_bus = a_bus | b_bus;
      4'd2, 4'd7:   c_bus = ~(a_bus | b_bus);
      4'd3, 4'd8:   c_bus = sum[W-1:0];
      4'd4:         c_bus = a_bus >> b_bus[SH-1:0];
      4'd9:         c_bus = a_bus << 2;
      4'd10:        c_bus = a_bus << 10;
      4'd11:        c_bus = {{(W-IMM){1'b0}}, a_bus[IMM-1:0]};
      4'd12:        c_bus = {{(W-IMM){a_bus[IMM-1]}}, a_bus[IMM-1:0]};
      4'd13, 4'd14: c_bus = inc_val;
      default:      c_bus = a_bus >> 5;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      flags <= 4'b0;
    else if (flag_en && is_cc)
      flags <= {c_bus[W-1], ~|c_bus,
                (fn == 4'd3) & add_v, (fn == 4'd3) & sum[W]};
  end

  // R10
  reset_clear_chk: assert property (@(posedge clk) rst |=> flags == 4'b0);
  // R9
  hold_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (!flag_en || !is_cc) |=> $stable(flags));
  // R8
  logic_vc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_en && fn < 4'd3) |=> flags[1:0] == 2'b00);
  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_en && is_cc && c_bus == '0) |=> flags[2]);
  // R6
  always_comb begin
    if (fn == 4'd13) inc_one_chk: assert (c_bus - a_bus == W'(1));
  end
endmodule

// File: tb/ucode_alu_bench.sv
module ucode_alu_bench;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst = 1, flag_en = 0;
  logic [3:0] fn = 0;
  logic [31:0] a = 0, b = 0, c;
  logic [3:0] fl;
  int vecs = 0, bad = 0;
  logic [3:0] mflags = 0;
  bit done = 0;

  ucode_alu u_ucode_alu (.clk(clk), .rst(rst), .fn(fn), .flag_en(flag_en),
    .a_bus(a), .b_bus(b), .c_bus(c), .flags(fl));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic longint unsigned ref_res(int f, longint unsigned x, longint unsigned y);
    longint unsigned r;
    case (f)
      0, 5: r = x & y;
      1, 6: r = x | y;
      2, 7: r = ~(x | y);
      3, 8: r = x + y;
      4: r = x >> (y % 32);
      9: r = x * 4;
      10: r = x * 1024;
      11: r = x % 8192;
      12: r = (x % 8192 >= 4096) ? (x % 8192) + 64'hFFFFE000 : x % 8192;
      13: r = x + 1;
      14: r = x + 4;
      default: r = x / 32;
    endcase
    return r & 64'hFFFFFFFF;
  endfunction

  function automatic string tag(int f);
    case (f)
      0,1,2,5,6,7: return "R1";
      3,8: return "R2";
      4: return "R3";
      9,10,15: return "R4";
      11,12: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic apply(int f, logic [31:0] x, logic [31:0] y, bit en);
    longint unsigned r, full;
    logic [3:0] nf;
    fn = 4'(f); a = x; b = y; flag_en = en;
    #1;
    r = ref_res(f, x, y);
    vecs++;
    if (c !== r[31:0]) begin
      bad++; $display("FAIL %s fn=%0d c=%h exp=%h", tag(f), f, c, r[31:0]);
    end
    nf = mflags;
    if (en && f <= 3) begin
      full = longint'(x) + longint'(y);
      nf[3] = r[31]; nf[2] = (r[31:0] == 0);
      nf[1] = (f == 3) && (x[31] == y[31]) && (r[31] != x[31]);
      nf[0] = (f == 3) && full[32];
    end
    @(posedge clk); mflags = nf; #2;
    vecs++;
    if (fl !== mflags) begin
      bad++; $display("FAIL %s flags=%b exp=%b", (en && f <= 3) ? "R7/R8" : "R9", fl, mflags);
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    if (!done) begin bad++; $display("FAIL watchdog"); $display("== %0d vectors applied, %0d miscompares ==", vecs, bad); $finish; end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    vecs++; if (fl !== 0) begin bad++; $display("FAIL R10 reset flags=%b exp=0", fl); end
    rst = 0; mflags = 0;
    apply(3, 32'h7FFFFFFF, 32'h1, 1);
    apply(3, 32'hFFFFFFFF, 32'h1, 1);
    apply(4, 32'h80000000, 32'hFFFFFFE3, 1);
    apply(13, 32'hFFFFFFFF, 32'h0, 1);
    apply(3, 32'h80000000, 32'h80000000, 0);
    apply(0, 32'hF0F0F0F0, 32'h0F0F0F0F, 1);
    apply(3, 32'h80000000, 32'h80000000, 1);
    apply(2, 32'h0, 32'h0, 1);
    apply(12, 32'h00001000, 32'h0, 1);
    apply(12, 32'hFFFF0FFF, 32'h0, 1);
    apply(11, 32'hFFFFFFFF, 32'h0, 1);
    apply(14, 32'hFFFFFFFE, 32'h5, 1);
    apply(9, 32'hC0000001, 32'h0, 1);
    apply(10, 32'h003FFFFF, 32'h0, 1);
    apply(15, 32'hFFFFFFFF, 32'h0, 1);
    apply(4, 32'hFFFFFFFF, 32'h0, 1);
    apply(4, 32'hFFFFFFFF, 32'h1F, 1);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] x, y;
      x = $urandom; y = $urandom;
      if (i % 7 == 0) y = x;
      apply(i % 16, x, y, (i % 3) != 0);
    end
    fn = 3; a = 32'hFFFFFFFF; b = 32'h1; flag_en = 1; rst = 1;
    @(posedge clk); #2; mflags = 0; vecs++;
    if (fl !== 0) begin bad++; $display("FAIL R10 flags=%b exp=0", fl); end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule